// File: doc/BRIEF.md
# Chip-Select Unit with Boot Mode

This block turns bus accesses into active-low external chip selects. It holds a small bank of channels. Each channel has a base page, a compare mask with a valid bit, and a control word that sets the port width, enables automatic acknowledge and gives the wait-state count. On each access the upper 16 bits of the bus address (the "page") are compared against every valid channel. The lowest-numbered matching channel drives its select low. If that channel has automatic acknowledge enabled, the block raises a one-cycle acknowledge once the channel's wait states have elapsed.

Channel 0 starts in a boot mode. From reset it selects on every access at any address, and every other channel stays quiet. This lets a boot memory answer before software has set up the map. Boot mode ends the first time software writes a 1 to channel 0's valid bit, and after that only a reset brings it back. If channel 0's base page is loaded before boot mode ends, channel 0 keeps answering for that range afterwards.

Software reaches the registers through a 32-bit port indexed by longword. Each channel owns four longwords: base page, mask, control, and one reserved slot.

Top module: `chip_select_unit`

## Requirements
- R1: After reset, every base page and mask reads 0. The channel 0 control word reads 0x0000009F (15 wait states, acknowledge on, port code 2'b10). Every other control word reads 0x00000080.
- R2: While boot mode is active, an access at any page pulls cs_n[0] low and holds every other select high, even if another valid channel matches.
- R3: Writing the channel 0 mask longword (index 1) with bit 0 set ends boot mode. From the next access on, every channel decodes by page.
- R4: Boot mode never returns without a reset. After channel 0's valid bit is cleared, channel 0 stays deasserted for every page.
- R5: A base page written to channel 0 before boot mode ends is decoded by channel 0 after boot mode ends.
- R6: Channel n matches when its valid bit is 1 and (page & ~mask) == (base & ~mask). The registers sit at longword index 4n (base in bits [15:0]), 4n+1 (mask in bits [31:16], valid in bit 0) and 4n+2 (control).
- R7: When several valid channels match, only the lowest-numbered one asserts, so at most one select is ever low.
- R8: All selects are high whenever the access strobe is low.
- R9: With acknowledge on (control bit 4), auto_ack is high for exactly one cycle: the cycle that is W cycles after the strobe rises, where W is control bits [3:0]. With W = 0 that is the first strobe cycle. With acknowledge off, or when no channel is selected, auto_ack stays low.
- R10: Index 4n+3 and every index at or above 4*NUM_CH read as zero. Bits [31:16] of the base and control longwords, and mask bits [15:1], read as zero and ignore writes.
- R11: The port-size field (control bits [7:6]) always reads 2'b10, the 16-bit port, whatever was written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_page | input | 16 | Upper 16 bits of the access address |
| bus_stb | input | 1 | High for the whole duration of an access |
| reg_idx | input | 6 | Register longword index |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cs_n | output | NUM_CH | Active-low chip selects |
| auto_ack | output | 1 | One-cycle automatic acknowledge |

## Verification
The bench targets the boot-mode edges:
- A valid channel 1 that overlaps channel 0 during boot mode. A design that decodes too early would drop channel 1's select low alongside channel 0.
- Clearing channel 0's valid bit after boot mode has ended. A design that derives boot mode from the current valid bit would fall back into select-everything.
- A base page loaded before boot exit. A design that ignores it would leave channel 0 silent.

Overlapping ranges with different masks check the lowest-channel priority. Acknowledge timing is checked at 0, 2 and 15 wait states, where an off-by-one counter would shift the pulse or repeat it. Random maps and pages are compared against a bench model of the match rule.

// File: rtl/csu_pkg.sv
// Package: shared widths, register select codes and control-word layout for
// the chip-select unit. Assumes a 16-bit page compare and 4-bit wait counts.
package csu_pkg;
    localparam int CSU_PAGE_W = 16;
    localparam int CSU_WAIT_W = 4;
    localparam int CSU_DATA_W = 32;
    localparam int CSU_IDX_W  = 6;
    localparam int CSU_PS_W   = 2;

    localparam logic [CSU_PS_W-1:0]   CSU_PS_16   = 2'b10;
    localparam logic [CSU_WAIT_W-1:0] CSU_BOOT_WS = '1;

    // Longword slot inside a channel's four-word window.
    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_RSVD = 2'd3
    } csu_sel_e;

    // Packs a control longword: [7:6] port code, [4] ack enable, [3:0] waits.
    function automatic logic [CSU_DATA_W-1:0] pack_ctl(input logic aa,
                                                       input logic [CSU_WAIT_W-1:0] ws);
        logic [CSU_DATA_W-1:0] w;
        w      = '0;
        w[7:6] = CSU_PS_16;
        w[4]   = aa;
        w[CSU_WAIT_W-1:0] = ws;
        return w;
    endfunction
endpackage

// File: rtl/csu_regs.sv
// Register bank: holds base page, mask, valid, ack enable and wait count for
// each channel, and the sticky boot flag. Assumes writes arrive as full
// longwords; reads are combinational. Port code is fixed to the 16-bit value.
module csu_regs
    import csu_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [CSU_IDX_W-1:0]                   reg_idx,
    input  logic                                   reg_we,
    input  logic [CSU_DATA_W-1:0]                  reg_wdata,
    output logic [CSU_DATA_W-1:0]                  reg_rdata,
    output logic [NUM_CH-1:0][CSU_PAGE_W-1:0]      base_o,
    output logic [NUM_CH-1:0][CSU_PAGE_W-1:0]      mask_o,
    output logic [NUM_CH-1:0]                      valid_o,
    output logic [NUM_CH-1:0]                      aa_o,
    output logic [NUM_CH-1:0][CSU_WAIT_W-1:0]      wait_o,
    output logic                                   boot_o
);
    localparam int CH_FIELD_W = CSU_IDX_W - 2;

    logic [CH_FIELD_W-1:0] ch_field;
    csu_sel_e              sel;
    logic                  ch_in_range;
    logic                  boot_q;

    assign ch_field    = reg_idx[CSU_IDX_W-1:2];
    assign sel         = csu_sel_e'(reg_idx[1:0]);
    assign ch_in_range = (int'(ch_field) < NUM_CH);

    // Boot flag: set by reset, cleared forever by a valid write to channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            boot_q <= 1'b1;
        else if (reg_we && ch_field == '0 && sel == SEL_MASK && reg_wdata[0])
            boot_q <= 1'b0;
    end
    assign boot_o = boot_q;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_ch
            logic wr_hit;
            assign wr_hit = reg_we && ch_in_range && (int'(ch_field) == g);

            // Per-channel storage with channel 0 taking the boot control defaults.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    base_o[g]  <= '0;
                    mask_o[g]  <= '0;
                    valid_o[g] <= 1'b0;
                    aa_o[g]    <= (g == 0);
                    wait_o[g]  <= (g == 0) ? CSU_BOOT_WS : '0;
                end else if (wr_hit) begin
                    case (sel)
                        SEL_BASE: base_o[g] <= reg_wdata[CSU_PAGE_W-1:0];
                        SEL_MASK: begin
                            mask_o[g]  <= reg_wdata[CSU_DATA_W-1 -: CSU_PAGE_W];
                            valid_o[g] <= reg_wdata[0];
                        end
                        SEL_CTL: begin
                            aa_o[g]   <= reg_wdata[4];
                            wait_o[g] <= reg_wdata[CSU_WAIT_W-1:0];
                        end
                        default: ;
                    endcase
                end
            end
        end
    endgenerate

    // Read mux: reserved slots and out-of-range channels return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_in_range && int'(ch_field) == i) begin
                case (sel)
                    SEL_BASE: reg_rdata = {{(CSU_DATA_W-CSU_PAGE_W){1'b0}}, base_o[i]};
                    SEL_MASK: reg_rdata = {mask_o[i], {(CSU_DATA_W-CSU_PAGE_W-1){1'b0}}, valid_o[i]};
                    SEL_CTL:  reg_rdata = pack_ctl(aa_o[i], wait_o[i]);
                    default:  reg_rdata = '0;
                endcase
            end
        end
    end

    AST_BOOT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_q |=> !boot_q); // R4
    AST_BOOT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_idx == CSU_IDX_W'(1) && reg_wdata[0]) |=> !boot_q); // R3
endmodule

// File: rtl/csu_decode.sv
// Page decoder: compares the access page against every valid channel and
// picks the lowest-numbered hit; in boot mode forces channel 0 alone.
// Assumes bus_page is stable while bus_stb is high.
module csu_decode
    import csu_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_stb,
    input  logic [CSU_PAGE_W-1:0]             bus_page,
    input  logic [NUM_CH-1:0][CSU_PAGE_W-1:0] base_i,
    input  logic [NUM_CH-1:0][CSU_PAGE_W-1:0] mask_i,
    input  logic [NUM_CH-1:0]                 valid_i,
    input  logic                              boot_i,
    output logic [NUM_CH-1:0]                 cs_n,
    output logic                              hit,
    output logic [CH_W-1:0]                   win
);
    logic [NUM_CH-1:0] match;
    logic              any_match;

    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_cmp
            // Masked page compare for one channel.
            assign match[g] = valid_i[g] &&
                ((bus_page & ~mask_i[g]) == (base_i[g] & ~mask_i[g]));
        end
    endgenerate

    // Priority pick: scanning downward leaves the lowest matching index.
    always_comb begin
        win       = '0;
        any_match = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (match[i]) begin
                win       = CH_W'(i);
                any_match = 1'b1;
            end
        end
        if (boot_i) begin
            win       = '0;
            any_match = 1'b1;
        end
    end

    assign hit = bus_stb && any_match;

    // Select drive: only the winning channel goes low, and only during a strobe.
    always_comb begin
        cs_n = '1;
        if (hit)
            cs_n[win] = 1'b0;
    end

    AST_BOOT_CS0: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_i && bus_stb) |-> (cs_n == {{(NUM_CH-1){1'b1}}, 1'b0})); // R2
    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R7
    AST_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stb |-> (&cs_n)); // R8
endmodule

// File: rtl/csu_ack.sv
// Wait-state timer: counts strobe cycles from the start of an access and
// raises a one-cycle acknowledge when the count equals the wait setting.
// Assumes the strobe drops between accesses.
module csu_ack
    import csu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_stb,
    input  logic                  hit,
    input  logic                  aa_en,
    input  logic [CSU_WAIT_W-1:0] wait_cnt,
    output logic                  ack
);
    localparam int CNT_W = CSU_WAIT_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1 << CSU_WAIT_W);

    logic [CNT_W-1:0] cnt_q;

    // Strobe-cycle counter, saturating past the largest wait so ack cannot repeat.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_stb)
            cnt_q <= '0;
        else if (cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    assign ack = hit && aa_en && (cnt_q == {1'b0, wait_cnt});

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R9
    AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (hit && bus_stb)); // R9
endmodule

// File: rtl/chip_select_unit.sv
// Top: chip-select unit with boot mode. Ties the register bank, the page
// decoder and the wait-state timer; routes the winner's ack settings to
// the timer. Assumes a single clock and synchronous active-low reset.
module chip_select_unit
    import csu_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CSU_PAGE_W-1:0]  bus_page,
    input  logic                   bus_stb,
    input  logic [CSU_IDX_W-1:0]   reg_idx,
    input  logic                   reg_we,
    input  logic [CSU_DATA_W-1:0]  reg_wdata,
    output logic [CSU_DATA_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0]      cs_n,
    output logic                   auto_ack
);
    logic [NUM_CH-1:0][CSU_PAGE_W-1:0] base_w;
    logic [NUM_CH-1:0][CSU_PAGE_W-1:0] mask_w;
    logic [NUM_CH-1:0]                 valid_w;
    logic [NUM_CH-1:0]                 aa_w;
    logic [NUM_CH-1:0][CSU_WAIT_W-1:0] wait_w;
    logic                              boot_w;
    logic                              hit_w;
    logic [CH_W-1:0]                   win_w;

    csu_regs #(.NUM_CH(NUM_CH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_idx   (reg_idx),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .base_o    (base_w),
        .mask_o    (mask_w),
        .valid_o   (valid_w),
        .aa_o      (aa_w),
        .wait_o    (wait_w),
        .boot_o    (boot_w)
    );

    csu_decode #(.NUM_CH(NUM_CH)) i_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_stb  (bus_stb),
        .bus_page (bus_page),
        .base_i   (base_w),
        .mask_i   (mask_w),
        .valid_i  (valid_w),
        .boot_i   (boot_w),
        .cs_n     (cs_n),
        .hit      (hit_w),
        .win      (win_w)
    );

    csu_ack i_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_stb  (bus_stb),
        .hit      (hit_w),
        .aa_en    (aa_w[win_w]),
        .wait_cnt (wait_w[win_w]),
        .ack      (auto_ack)
    );
endmodule

// File: tb/test_chip_select_unit.sv
// Bench: directed boot-mode corners plus seeded random maps checked by a model.
module test_chip_select_unit;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_page = '0;
    logic        bus_stb = 1'b0;
    logic [5:0]  reg_idx = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCH-1:0] cs_n;
    logic        auto_ack;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [15:0] m_base [NCH];
    logic [15:0] m_mask [NCH];
    bit          m_valid [NCH];
    bit          m_aa [NCH];
    int          m_wait [NCH];
    bit          m_boot;

    chip_select_unit #(.NUM_CH(NCH)) i_chip_select_unit (
        .clk(clk), .rst_n(rst_n), .bus_page(bus_page), .bus_stb(bus_stb),
        .reg_idx(reg_idx), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cs_n(cs_n), .auto_ack(auto_ack)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_base[i] = '0; m_mask[i] = '0; m_valid[i] = 0;
            m_aa[i] = (i == 0); m_wait[i] = (i == 0) ? 15 : 0;
        end
        m_boot = 1;
    endtask

    function automatic int exp_win(input logic [15:0] pg);
        if (m_boot) return 0;
        for (int i = 0; i < NCH; i++)
            if (m_valid[i] && ((pg & ~m_mask[i]) == (m_base[i] & ~m_mask[i])))
                return i;
        return -1;
    endfunction

    function automatic logic [NCH-1:0] exp_cs(input int w);
        logic [NCH-1:0] v;
        v = '1;
        if (w >= 0) v[w] = 1'b0;
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input int idx);
        int ch;
        int sl;
        ch = idx / 4; sl = idx % 4;
        if (ch >= NCH) return 32'h0;
        case (sl)
            0: return {16'h0, m_base[ch]};
            1: return {m_mask[ch], 15'h0, 1'(m_valid[ch])};
            2: return {24'h0, 2'b10, 1'b0, 1'(m_aa[ch]), 4'(m_wait[ch])};
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input int idx, input logic [31:0] d);
        int ch;
        ch = idx / 4;
        @(posedge clk); #1;
        reg_idx = 6'(idx); reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
        if (ch < NCH) begin
            case (idx % 4)
                0: m_base[ch] = d[15:0];
                1: begin
                    m_mask[ch] = d[31:16]; m_valid[ch] = d[0];
                    if (ch == 0 && d[0]) m_boot = 0;
                end
                2: begin m_aa[ch] = d[4]; m_wait[ch] = int'(d[3:0]); end
                default: ;
            endcase
        end
    endtask

    task automatic rd(input string req, input int idx);
        @(posedge clk); #1;
        reg_idx = 6'(idx);
        @(negedge clk);
        check(req, reg_rdata, exp_read(idx));
    endtask

    // One access: select checked in the first cycle, ack checked over the whole window.
    task automatic access(input string req, input logic [15:0] pg);
        int w;
        int ack_at;
        int ack_n;
        int exp_at;
        w = exp_win(pg);
        ack_at = -1; ack_n = 0;
        @(posedge clk); #1;
        bus_page = pg; bus_stb = 1'b1;
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            if (k == 0) check({req, " select"}, 32'(cs_n), 32'(exp_cs(w)));
            if (auto_ack) begin ack_n++; if (ack_at < 0) ack_at = k; end
            if (k < 17) begin @(posedge clk); #1; end
        end
        exp_at = (w >= 0 && m_aa[w]) ? m_wait[w] : -1;
        check({req, " R9 ack cycle"}, 32'(ack_at), 32'(exp_at));
        check({req, " R9 ack count"}, 32'(ack_n), (exp_at >= 0) ? 32'd1 : 32'd0);
        @(posedge clk); #1;
        bus_stb = 1'b0;
        @(negedge clk);
        check("R8 idle", 32'(cs_n), 32'(exp_cs(-1)));
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd("R1 ch0 ctl", 2);
        rd("R1 ch1 ctl", 6);
        rd("R1 ch1 base", 4);
        rd("R1 ch0 mask", 1);
        @(negedge clk);
        check("R8 after reset", 32'(cs_n), 32'hF);

        // R2 boot mode selects channel 0 everywhere, ack after 15 waits
        access("R2 boot any page", 16'hABCD);
        wr(4, 32'h0000_1000); wr(5, 32'h0000_0001);
        access("R2 boot ignores ch1", 16'h1000);

        // R10 upper half ignored; R5 base before exit; R3 exit
        wr(0, 32'hDEAD_2000);
        rd("R10 base upper zero", 0);
        wr(2, 32'hFFFF_FF12);
        rd("R11 ps forced", 2);
        wr(1, 32'h0000_0001);
        access("R5 ch0 keeps range", 16'h2000);
        access("R3 ch1 decodes", 16'h1000);
        access("R3 no match", 16'h3000);

        // R10 reserved reads
        rd("R10 rsvd slot", 3);
        rd("R10 rsvd slot ch2", 11);
        rd("R10 beyond channels", 16);
        rd("R10 top index", 63);

        // R7 priority and R6 mask compare; zero-wait ack on ch2
        wr(8, 32'h0000_1000); wr(9, 32'h00FF_0001); wr(10, 32'h0000_0010);
        access("R7 lowest wins", 16'h1000);
        wr(5, 32'h00F0_0001);
        access("R6 masked miss then ch2", 16'h1005);
        access("R6 masked hit ch1", 16'h1070);

        // R4 clearing valid does not restore boot
        wr(1, 32'h0000_0000);
        access("R4 no boot return", 16'h5555);
        access("R4 ch0 silent", 16'h2000);

        // Random maps checked against the model
        for (int r = 0; r < 6; r++) begin
            for (int c = 0; c < NCH; c++) begin
                wr(c * 4, $urandom());
                wr(c * 4 + 1, ($urandom() & 32'h0F0F_0000) | 32'($urandom_range(0, 3) != 0));
                wr(c * 4 + 2, $urandom());
                rd("R11 R10 ctl readback", c * 4 + 2);
                rd("R6 mask readback", c * 4 + 1);
            end
            for (int a = 0; a < 8; a++) begin
                logic [15:0] pg;
                int pick;
                pick = $urandom_range(0, NCH);
                pg = (pick < NCH) ? (m_base[pick] ^ (16'($urandom()) & m_mask[pick])) : 16'($urandom());
                access("R6 R7 random", pg);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule